// File: doc/BRIEF.md
# Receive Alarm Fill Stage

This stage sits on the receive byte path of every channel, between framing and the elastic aligner. For each channel it either forwards the incoming byte unchanged or replaces it with an all-ones alarm indication signal (AIS). The choice depends on four inputs: a force bit, a loss-of-frame (LOF) status with a per-channel policy bit, and a power-down flag for the channel's recovery path. The fill is applied here, before the aligner, so the alarm pattern is present in the data before any rate adaptation takes place.

Every channel has one register stage. A byte and its strobe come out one clock after they go in. A per-channel flag comes out in the same cycle and marks the bytes that carry the alarm. A decision changes only when a byte is taken, so a switch never lands inside a byte. A powered-down channel is the exception: it shows all-ones on every cycle, whether or not a byte is offered. The number of channels and the byte width are parameters.

Top module: `ais_insert_top`

## Requirements
- R1: When a byte is offered (`in_valid` high) while `lof` and `ais_on_lof` are both high, the byte shown on that channel one clock later is all-ones (8'hFF at the default width).
- R2: When a byte is offered while `lof` is high and `ais_on_lof` is low, and neither force nor power-down is set, the byte passes unchanged one clock later and `ais_active` is low.
- R3: When a byte is offered with `force_ais` high, the output byte one clock later is all-ones, whatever the state of `lof`.
- R4: `ais_active` is high in exactly the cycles whose output byte was produced by alarm fill (force, LOF with policy set, or power-down). It is aligned with that byte.
- R5: While `pwr_down` is high, the channel's output byte is all-ones one clock later and `ais_active` is high, whether or not a byte is offered.
- R6: In a cycle with no offered byte and no power-down, the channel's output byte and `ais_active` keep their previous values.
- R7: `out_valid` of a channel equals that channel's `in_valid` from one clock earlier. An unaffected byte appears unchanged one clock after it is taken.
- R8: Channels are independent: the controls of one channel never change another channel's output.
- R9: While reset is asserted, and until the first byte arrives, every channel shows `out_valid` low, an all-ones byte and `ais_active` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | NCH*DW | Received bytes; channel c occupies bits [c*DW +: DW] |
| in_valid | input | NCH | Byte strobe per channel |
| lof | input | NCH | Loss-of-frame status per channel |
| ais_on_lof | input | NCH | Policy: 1 fills with AIS on LOF, 0 passes through |
| force_ais | input | NCH | Unconditional alarm fill per channel |
| pwr_down | input | NCH | Recovery path powered down per channel |
| out_data | output | NCH*DW | Conditioned bytes, same lane layout as input |
| out_valid | output | NCH | Byte strobe, one clock after input |
| ais_active | output | NCH | Output byte of this channel is alarm fill |

## Verification
A wrong held flag or a wrong held data register shows at the ports in the next cycle: a byte that should have been forwarded arrives as all-ones, or the reverse, or `ais_active` disagrees with the byte beside it. A hold fault is visible only once a cycle with no strobe leaves the output stale or changed. For that reason the stimulus mixes gaps and bursts, and in those stretches the control bits change between bytes. Any fault is caught within one clock of the stimulus that exposes it, because the bench compares every channel on every clock.

// File: rtl/ais_insert_pkg.sv
package ais_insert_pkg;

    // Reason the lane chose alarm fill for the byte being registered
    typedef enum logic [1:0] {
        FILL_NONE  = 2'd0,
        FILL_FORCE = 2'd1,
        FILL_LOF   = 2'd2,
        FILL_POWER = 2'd3
    } fill_cause_e;

    // Decision made for one lane in one cycle
    typedef struct packed {
        logic        take;   // a byte is being accepted or power-down forces an update
        logic        fill;   // the registered byte must be all-ones
        fill_cause_e cause;
    } lane_ctl_t;

endpackage

// File: rtl/ais_insert_decide.sv
module ais_insert_decide
    import ais_insert_pkg::*;
(
    input  logic      valid_i,
    input  logic      lof_i,
    input  logic      lof_mode_i,
    input  logic      force_i,
    input  logic      pwr_down_i,
    output lane_ctl_t ctl_o
);

    always_comb begin
        ctl_o       = '0;
        ctl_o.cause = FILL_NONE;
        if (pwr_down_i) begin
            ctl_o.take  = 1'b1;
            ctl_o.fill  = 1'b1;
            ctl_o.cause = FILL_POWER;
        end else if (valid_i) begin
            ctl_o.take = 1'b1;
            if (force_i) begin
                ctl_o.fill  = 1'b1;
                ctl_o.cause = FILL_FORCE;
            end else if (lof_i && lof_mode_i) begin
                ctl_o.fill  = 1'b1;
                ctl_o.cause = FILL_LOF;
            end
        end
    end

endmodule

// File: rtl/ais_insert_lane.sv
module ais_insert_lane
    import ais_insert_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    input  lane_ctl_t     ctl_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          flag_o
);

    localparam logic [DW-1:0] AIS_WORD = {DW{1'b1}};

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          flag;
    } lane_reg_t;

    lane_reg_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (ctl_i.take) begin
            st_d.data = ctl_i.fill ? AIS_WORD : data_i;
            st_d.flag = ctl_i.fill;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= AIS_WORD;
            st_q.valid <= 1'b0;
            st_q.flag  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign flag_o  = st_q.flag;

endmodule

// File: rtl/ais_insert_top.sv
module ais_insert_top
    import ais_insert_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] in_data,
    input  logic [NCH-1:0]    in_valid,
    input  logic [NCH-1:0]    lof,
    input  logic [NCH-1:0]    ais_on_lof,
    input  logic [NCH-1:0]    force_ais,
    input  logic [NCH-1:0]    pwr_down,
    output logic [NCH*DW-1:0] out_data,
    output logic [NCH-1:0]    out_valid,
    output logic [NCH-1:0]    ais_active
);

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        lane_ctl_t ctl;

        ais_insert_decide u_decide (
            .valid_i    (in_valid[c]),
            .lof_i      (lof[c]),
            .lof_mode_i (ais_on_lof[c]),
            .force_i    (force_ais[c]),
            .pwr_down_i (pwr_down[c]),
            .ctl_o      (ctl)
        );

        ais_insert_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .data_i  (in_data[c*DW +: DW]),
            .valid_i (in_valid[c]),
            .ctl_i   (ctl),
            .data_o  (out_data[c*DW +: DW]),
            .valid_o (out_valid[c]),
            .flag_o  (ais_active[c])
        );
    end

endmodule

// File: rtl/ais_insert_chk.sv
module ais_insert_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*DW-1:0] in_data,
    input logic [NCH-1:0]    in_valid,
    input logic [NCH-1:0]    lof,
    input logic [NCH-1:0]    ais_on_lof,
    input logic [NCH-1:0]    force_ais,
    input logic [NCH-1:0]    pwr_down,
    input logic [NCH*DW-1:0] out_data,
    input logic [NCH-1:0]    out_valid,
    input logic [NCH-1:0]    ais_active
);

    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_LOF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[c] && lof[c] && ais_on_lof[c]) |=> (out_data[c*DW +: DW] == ONES)); // R1

        AST_LOF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[c] && lof[c] && !ais_on_lof[c] && !force_ais[c] && !pwr_down[c])
            |=> (out_data[c*DW +: DW] == $past(in_data[c*DW +: DW]) && !ais_active[c])); // R2

        AST_FORCE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[c] && force_ais[c]) |=> (out_data[c*DW +: DW] == ONES)); // R3

        AST_FLAG_MEANS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            ais_active[c] |-> (out_data[c*DW +: DW] == ONES)); // R4

        AST_POWER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_down[c] |=> (out_data[c*DW +: DW] == ONES && ais_active[c])); // R5

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_valid[c] && !pwr_down[c])
            |=> ($stable(out_data[c*DW +: DW]) && $stable(ais_active[c]))); // R6

        AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[c] |=> out_valid[c]); // R7

        AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid[c] |=> !out_valid[c]); // R7
    end

endmodule

bind ais_insert_top ais_insert_chk #(.NCH(NCH), .DW(DW)) chk_i (.*);

// File: tb/ais_insert_top_tb_top.sv
module ais_insert_top_tb_top;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int TCK = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] in_data = '0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH-1:0]    lof = '0;
    logic [NCH-1:0]    ais_on_lof = '0;
    logic [NCH-1:0]    force_ais = '0;
    logic [NCH-1:0]    pwr_down = '0;
    logic [NCH*DW-1:0] out_data;
    logic [NCH-1:0]    out_valid;
    logic [NCH-1:0]    ais_active;

    int checks = 0;
    int failures = 0;

    // behavioural model state, one entry per channel
    int exp_data  [NCH];
    int exp_flag  [NCH];
    int exp_valid [NCH];
    string why    [NCH];

    always #(TCK/2) clk = ~clk;

    ais_insert_top #(.NCH(NCH), .DW(DW)) dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // compare every channel against the model (R8: each lane judged on its own)
    task automatic compare_all();
        for (int c = 0; c < NCH; c++) begin
            int d = int'(out_data[c*DW +: DW]);
            check(d == exp_data[c], why[c], d, exp_data[c]);
            check(int'(ais_active[c]) == exp_flag[c], {why[c], "/R4 flag"}, int'(ais_active[c]), exp_flag[c]);
            check(int'(out_valid[c]) == exp_valid[c], "R7 strobe", int'(out_valid[c]), exp_valid[c]);
        end
    endtask

    // advance the model with the inputs now on the pins
    task automatic model_step();
        for (int c = 0; c < NCH; c++) begin
            exp_valid[c] = int'(in_valid[c]);
            if (pwr_down[c]) begin
                exp_data[c] = 255; exp_flag[c] = 1; why[c] = "R5 power-down";
            end else if (in_valid[c]) begin
                if (force_ais[c]) begin
                    exp_data[c] = 255; exp_flag[c] = 1; why[c] = "R3 force";
                end else if (lof[c] && ais_on_lof[c]) begin
                    exp_data[c] = 255; exp_flag[c] = 1; why[c] = "R1 lof fill";
                end else begin
                    exp_data[c] = int'(in_data[c*DW +: DW]); exp_flag[c] = 0;
                    why[c] = lof[c] ? "R2 lof pass" : "R7 pass";
                end
            end else begin
                why[c] = "R6 hold";
            end
        end
    endtask

    // one cycle: on falling edge compare, drive new inputs, update model
    task automatic cycle(input int p_valid, input int p_lof, input int p_mode,
                         input int p_force, input int p_pwr);
        @(negedge clk);
        compare_all();
        for (int c = 0; c < NCH; c++) begin
            in_data[c*DW +: DW] = 8'($urandom);
            in_valid[c]   = ($urandom_range(99) < p_valid);
            lof[c]        = ($urandom_range(99) < p_lof);
            ais_on_lof[c] = ($urandom_range(99) < p_mode);
            force_ais[c]  = ($urandom_range(99) < p_force);
            pwr_down[c]   = ($urandom_range(99) < p_pwr);
        end
        model_step();
    endtask

    initial begin
        #(TCK * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_data[c] = 255; exp_flag[c] = 1; exp_valid[c] = 0; why[c] = "R9 reset";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();            // R9 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();            // R9 after release, before any byte
        for (int c = 0; c < NCH; c++) why[c] = "R9 idle";

        repeat (200) cycle(100, 0, 0, 0, 0);     // plain forwarding, R7
        repeat (200) cycle(100, 80, 0, 0, 0);    // LOF with pass policy, R2
        repeat (200) cycle(100, 80, 100, 0, 0);  // LOF with fill policy, R1
        repeat (200) cycle(100, 50, 50, 30, 0);  // force mixed with LOF, R3
        repeat (300) cycle(40, 50, 50, 20, 0);   // gaps between bytes, R6
        repeat (300) cycle(60, 50, 50, 20, 25);  // power-down episodes, R5
        repeat (2000) cycle(70, 40, 50, 15, 10); // mixed traffic, R8

        // R8 directed: lane 0 forced while others forward
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            compare_all();
            for (int c = 0; c < NCH; c++) begin
                in_data[c*DW +: DW] = 8'(k * 7 + c);
                in_valid[c] = 1'b1; lof[c] = 1'b1; ais_on_lof[c] = 1'b0;
                force_ais[c] = (c == 0); pwr_down[c] = (c == NCH - 1) && k[2];
            end
            model_step();
        end
        @(negedge clk);
        compare_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule